// File: doc/BRIEF.md
# UART Receiver with Holding Register

This block receives asynchronous serial characters on a single line and delivers each finished character through an 8-bit holding register that the host can only read. A baud tick input supplies the 16x oversampling rate. The receiver finds a start bit, confirms it at mid-bit, and samples the data bits least significant first. It then checks the stop bit. At the end of each frame it copies the character into the holding register and gives a one-clock completion pulse.

Two enables control the block. `rxEn` decides whether finished frames are delivered at all. `blockEn` parks the whole receiver and forces the holding register to all ones. A length select picks 7-bit or 8-bit characters. The host acknowledges each character with `rdStrobe`. A character that completes while the previous one is still unacknowledged is dropped and raises a sticky overrun flag. A low stop bit raises a sticky framing flag, but that character is still delivered.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset, `holdData` is 8'hFF and `rxDone`, `overrunErr` and `frameErr` are 0.
- R2: With `len7`=0, a frame is one low start bit, then 8 data bits least significant first, then one stop bit. Each bit lasts 16 `baudTick` periods. The character is copied into `holdData` when the stop bit has been sampled.
- R3: Each copy into `holdData` is marked by `rxDone` high for exactly one clock cycle.
- R4: With `rxEn`=0, a completed frame changes neither `holdData` nor the flags, and gives no `rxDone` pulse.
- R5: With `len7`=1, a frame carries 7 data bits. They land in `holdData[6:0]`, and `holdData[7]` is 0.
- R6: A copy sets a pending state that `rdStrobe` clears. A frame that completes while pending is set raises `overrunErr`, leaves `holdData` unchanged and gives no `rxDone` pulse.
- R7: `overrunErr` and `frameErr` stay set until `errClear` is high for a cycle, and later good frames do not clear them.
- R8: A stop bit sampled low sets `frameErr`, and the character is still copied with an `rxDone` pulse.
- R9: A falling edge that is high again when re-checked at mid start bit (8th tick) returns the receiver to idle, and no character is received.
- R10: While `blockEn` is 0, `holdData` reads 8'hFF without a reset, starting one cycle later. During that time the receiver is held idle, and the pending state and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blockEn | input | 1 | Block enable; low forces the holding register to FFh |
| rxEn | input | 1 | Receive enable; low discards completed frames |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| rdStrobe | input | 1 | Host read acknowledge, clears pending |
| errClear | input | 1 | Clears the overrun and framing flags |
| holdData | output | 8 | Holding register |
| rxDone | output | 1 | One-cycle receive-complete pulse |
| overrunErr | output | 1 | Sticky overrun flag |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
The embedded assertions assume `baudTick` is a single-cycle pulse separated by idle cycles, and that `len7` and `rxEn` are held steady across a frame. The bench generates the tick every fourth clock. It changes the mode and enable inputs only between frames, while the line is idle. Serial bits are driven for exactly 64 clocks each, so the 16x sampling point stays well inside every bit even though the tick phase relative to the line edges varies.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;   // sample line into shift register
    logic frameDone;  // stop bit sampled, frame complete
  } rxStrobe_t;
endpackage

// File: rtl/rxh_ctrl.sv
module rxh_ctrl
  import rxh_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      blockEn,
  input  logic      baudTick,
  input  logic      len7,
  input  logic      rxSync,
  input  logic      rxFall,
  output rxStrobe_t strobe
);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [TICK_W-1:0] HALF_T = TICK_W'(OVERSAMPLE/2 - 1);
  localparam logic [TICK_W-1:0] FULL_T = TICK_W'(OVERSAMPLE - 1);

  rxState_t          state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastBit;

  assign lastBit = len7 ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);

  always_comb begin
    strobe.shiftBit  = (state == ST_DATA) && baudTick && (tickCnt == FULL_T);
    strobe.frameDone = (state == ST_STOP) && baudTick && (tickCnt == FULL_T);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!blockEn) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (rxFall) state <= ST_START;
        end
        ST_START: if (baudTick) begin
          if (tickCnt == HALF_T) begin
            tickCnt <= '0;
            state   <= rxSync ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: if (baudTick) begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_T) begin
            if (bitCnt == lastBit) state <= ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STOP: if (baudTick) begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_T) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: data phase is entered only when the line was still low at mid start bit
  a_r9_start_recheck: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(rxSync));

  // R10: a disabled block does not leave idle
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blockEn |=> state == ST_IDLE);
endmodule

// File: rtl/rxh_dpath.sv
module rxh_dpath
  import rxh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blockEn,
  input  logic              rxEn,
  input  logic              len7,
  input  logic              rxLine,
  input  logic              rdStrobe,
  input  logic              errClear,
  input  rxStrobe_t         strobe,
  output logic              rxSync,
  output logic              rxFall,
  output logic [DATA_W-1:0] holdData,
  output logic              rxDone,
  output logic              overrunErr,
  output logic              frameErr
);
  logic              sync1, sync2, rxPrev;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] charWord;
  logic              pending;
  logic              pendingNow;
  logic              accept;
  logic              overrun;

  assign rxSync = sync2;
  assign rxFall = rxPrev & ~sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b1;
      sync2  <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      sync1  <= rxLine;
      sync2  <= sync1;
      rxPrev <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '1;
    else if (strobe.shiftBit) shiftReg <= {sync2, shiftReg[DATA_W-1:1]};
  end

  assign charWord   = len7 ? {1'b0, shiftReg[DATA_W-1:1]} : shiftReg;
  assign pendingNow = pending & ~rdStrobe;
  assign accept     = strobe.frameDone & rxEn & ~pendingNow;
  assign overrun    = strobe.frameDone & rxEn & pendingNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdData   <= '1;
      rxDone     <= 1'b0;
      pending    <= 1'b0;
      overrunErr <= 1'b0;
      frameErr   <= 1'b0;
    end else if (!blockEn) begin
      holdData   <= '1;
      rxDone     <= 1'b0;
      pending    <= 1'b0;
      overrunErr <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      rxDone <= accept;
      if (accept) begin
        holdData <= charWord;
        pending  <= 1'b1;
      end else if (rdStrobe) begin
        pending  <= 1'b0;
      end
      if (overrun) overrunErr <= 1'b1;
      else if (errClear) overrunErr <= 1'b0;
      if (accept && !sync2) frameErr <= 1'b1;
      else if (errClear) frameErr <= 1'b0;
    end
  end

  // R3: completion pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxDone |=> !rxDone);

  // R2: holding register changes only together with a completion pulse
  a_r2_write_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(blockEn) && !$stable(holdData)) |-> rxDone);

  // R4: no pulse for a frame finished while reception was disabled
  a_r4_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    rxDone |-> $past(rxEn));

  // R5: 7-bit characters have bit 7 clear
  a_r5_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDone && $past(len7)) |-> !holdData[DATA_W-1]);

  // R6: an overrun leaves the register untouched
  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrunErr) |-> ($stable(holdData) && !rxDone));

  // R10: disabled block reads all ones
  a_r10_forced_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !blockEn |=> holdData == '1);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import rxh_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blockEn,
  input  logic              rxEn,
  input  logic              len7,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic              rdStrobe,
  input  logic              errClear,
  output logic [DATA_W-1:0] holdData,
  output logic              rxDone,
  output logic              overrunErr,
  output logic              frameErr
);
  rxStrobe_t strobe;
  logic      rxSync;
  logic      rxFall;

  rxh_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .blockEn  (blockEn),
    .baudTick (baudTick),
    .len7     (len7),
    .rxSync   (rxSync),
    .rxFall   (rxFall),
    .strobe   (strobe)
  );

  rxh_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .blockEn    (blockEn),
    .rxEn       (rxEn),
    .len7       (len7),
    .rxLine     (rxLine),
    .rdStrobe   (rdStrobe),
    .errClear   (errClear),
    .strobe     (strobe),
    .rxSync     (rxSync),
    .rxFall     (rxFall),
    .holdData   (holdData),
    .rxDone     (rxDone),
    .overrunErr (overrunErr),
    .frameErr   (frameErr)
  );
endmodule

// File: tb/test_uart_rx_hold.sv
`timescale 1ns/1ps
module test_uart_rx_hold;
  localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blockEn = 1'b1, rxEn = 1'b1, len7 = 1'b0;
  logic       baudTick = 1'b0, rxLine = 1'b1, rdStrobe = 1'b0, errClear = 1'b0;
  logic [7:0] holdData;
  logic       rxDone, overrunErr, frameErr;

  int testsRun = 0, testsFailed = 0;
  int doneCount = 0;
  logic [1:0] tickDiv = '0;

  uart_rx_hold i_uart_rx_hold (
    .clk(clk), .rst_n(rst_n), .blockEn(blockEn), .rxEn(rxEn), .len7(len7),
    .baudTick(baudTick), .rxLine(rxLine), .rdStrobe(rdStrobe), .errClear(errClear),
    .holdData(holdData), .rxDone(rxDone), .overrunErr(overrunErr), .frameErr(frameErr)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tickDiv  <= tickDiv + 2'd1;
    baudTick <= (tickDiv == 2'd3);
  end

  always @(negedge clk) if (rxDone) doneCount++;

  function automatic logic [7:0] expChar(input logic [7:0] d, input logic sevenBit);
    return sevenBit ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic sevenBit, input logic stopVal);
    int nb = sevenBit ? 7 : 8;
    @(negedge clk) rxLine = 1'b0;
    repeat (BIT_CLKS - 1) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk) rxLine = d[i];
      repeat (BIT_CLKS - 1) @(negedge clk);
    end
    @(negedge clk) rxLine = stopVal;
    repeat (BIT_CLKS - 1) @(negedge clk);
    @(negedge clk) rxLine = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  initial begin
    #1_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] d, prev;
    int c0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 hold", holdData, 8'hFF);
    check("R1 done", rxDone, 0);
    check("R1 ovr", overrunErr, 0);
    check("R1 frm", frameErr, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 R3: random 8-bit frames
    for (int k = 0; k < 8; k++) begin
      d = 8'($urandom);
      if (k == 0) d = 8'h01;
      if (k == 1) d = 8'h80;
      c0 = doneCount;
      sendFrame(d, 1'b0, 1'b1);
      check("R2 data8", holdData, expChar(d, 1'b0));
      check("R3 one pulse", doneCount - c0, 1);
      pulse(rdStrobe);
    end

    // R5: 7-bit frames
    len7 = 1'b1;
    for (int k = 0; k < 6; k++) begin
      d = 8'($urandom) | 8'h80;
      sendFrame(d, 1'b1, 1'b1);
      check("R5 data7", holdData, expChar(d, 1'b1));
      pulse(rdStrobe);
    end
    len7 = 1'b0;

    // R4: reception disabled
    prev = holdData;
    rxEn = 1'b0;
    c0 = doneCount;
    sendFrame(8'h5A, 1'b0, 1'b1);
    check("R4 hold kept", holdData, prev);
    check("R4 no pulse", doneCount - c0, 0);
    rxEn = 1'b1;

    // R6: overrun
    sendFrame(8'h3C, 1'b0, 1'b1);
    c0 = doneCount;
    sendFrame(8'hC3, 1'b0, 1'b1);
    check("R6 hold kept", holdData, 8'h3C);
    check("R6 flag", overrunErr, 1);
    check("R6 no pulse", doneCount - c0, 0);
    pulse(rdStrobe);
    // R7: sticky across a good frame, then cleared
    sendFrame(8'hA5, 1'b0, 1'b1);
    check("R7 data", holdData, 8'hA5);
    check("R7 sticky", overrunErr, 1);
    pulse(rdStrobe);
    pulse(errClear);
    @(negedge clk);
    check("R7 cleared", overrunErr, 0);

    // R8: framing error still transfers
    c0 = doneCount;
    sendFrame(8'h96, 1'b0, 1'b0);
    check("R8 data", holdData, 8'h96);
    check("R8 flag", frameErr, 1);
    check("R8 pulse", doneCount - c0, 1);
    pulse(rdStrobe);
    pulse(errClear);
    @(negedge clk);
    check("R7 frm cleared", frameErr, 0);

    // R9: false start glitch
    prev = holdData;
    c0 = doneCount;
    @(negedge clk) rxLine = 1'b0;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R9 no char", doneCount - c0, 0);
    check("R9 hold kept", holdData, prev);
    sendFrame(8'h4E, 1'b0, 1'b1);
    check("R9 recovers", holdData, 8'h4E);

    // R10: block disabled forces FFh without reset
    @(negedge clk) blockEn = 1'b0;
    @(negedge clk);
    check("R10 forced", holdData, 8'hFF);
    repeat (5) @(negedge clk);
    blockEn = 1'b1;
    @(negedge clk);
    check("R10 stays FF", holdData, 8'hFF);
    sendFrame(8'h27, 1'b0, 1'b1);
    check("R10 pending cleared", holdData, 8'h27);
    check("R10 no overrun", overrunErr, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule